// File: doc/BRIEF.md
# Three-Level Sigma-Delta Modulator

This block turns a stream of signed PCM samples into a pulse-density pattern for a filterless bridge-tied speaker stage. Each of its two output legs is a plain ground/supply switch. The difference between the legs takes one of three values: positive, zero or negative. A second-order error-feedback loop with a ternary quantizer shapes the quantization noise away from the audio band. Because the quantizer has a zero level, the bridge rests at zero differential whenever the loop has nothing to correct. The load therefore carries current only when a pulse is needed.

The block has no fixed carrier. Pulse positions follow the loop state alone, so several instances can run side by side without any synchronization. A sample enters the loop only when its valid strobe is high. Between strobes, the loop keeps modulating the last accepted sample, one output decision per clock. Deasserting the enable parks both legs at ground and clears the loop memory.

Top module: `tlsd_mod`

## Requirements
- R1: The `level` output is a two-bit two's-complement value and only ever takes one of three codes: 2'b01 (+1), 2'b00 (0) or 2'b11 (-1). The code 2'b10 never appears.
- R2: The legs follow the level. +1 drives `leg_p` high and `leg_n` low. -1 drives `leg_n` high and `leg_p` low. 0 drives both legs low. Both legs are never high together.
- R3: Let FS = 2^(DW-1). Each enabled cycle, the loop forms v = x + 2*e1 - e2 from the held sample x and the two previous stored errors e1 and e2. It decides +1 when v > FS/2, -1 when v < -FS/2, and 0 otherwise. It then stores e = v - decision*FS as the new e1, and the old e1 becomes e2. The decision appears on the outputs after one clock edge.
- R4: With a held sample of zero and cleared loop state, `level` stays at 0 and both legs stay low for as long as the input remains zero.
- R5: Start from cleared state with a constant input x where |x| <= FS/4. Over N cycles, the sum of the `level` values is within 8 of N*x/FS, so pulse density rises with input magnitude and carries its sign.
- R6: `smp_data` is captured only at an edge where `smp_valid` is high. At any other edge, the previously held sample is kept and changes on `smp_data` have no effect on the outputs.
- R7: While `rst_n` is low, or from the edge after `en` is sampled low, both legs and `level` are 0 and the stored errors are zero. After re-enabling, the loop starts from that cleared state.
- R8: Each stored error is clamped to the range [-(2*FS-1), 2*FS-1] before it is kept, so a full-scale overload cannot wrap the loop arithmetic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock, one decision per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks the legs and clears the loop |
| smp_valid | input | 1 | Sample strobe; high captures `smp_data` |
| smp_data | input | DW | Signed PCM sample |
| leg_p | output | 1 | Positive leg switch drive (1 = supply, 0 = ground) |
| leg_n | output | 1 | Negative leg switch drive (1 = supply, 0 = ground) |
| level | output | 2 | Signed differential level, for monitoring |

## Verification
The checker evaluates several properties on every cycle. It confirms that the level code stays legal and that the legs agree with it, with no shoot-through. It confirms that both stored errors stay inside the clamp bound. It confirms that a low enable leaves the outputs quiet and the state cleared one edge later. It also confirms that a zero sample with cleared state produces no pulse. Three properties can only be shown through the bench's scenarios, which replay every decision against an independent integer model: the exact decision sequence, that density rises and carries the input's sign across several input magnitudes, and that unstrobed sample changes have no effect.

// File: rtl/tlsd_pkg.sv
package tlsd_pkg;

  // Ternary decision, encoded as a two-bit two's-complement value.
  typedef enum logic [1:0] {
    TRIT_ZERO = 2'b00,
    TRIT_POS  = 2'b01,
    TRIT_NEG  = 2'b11
  } trit_e;

  // Leg drive pair {positive leg, negative leg} for a decision.
  // Zero differential parks both switches at ground.
  function automatic logic [1:0] drive_of(trit_e t);
    case (t)
      TRIT_POS: return 2'b10;
      TRIT_NEG: return 2'b01;
      default:  return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/tlsd_hold.sv
module tlsd_hold #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  output logic signed [DW-1:0] held
);

  // Sample register: updated only on a strobe, otherwise held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (smp_valid) begin
      held <= smp_data;
    end
  end

endmodule

// File: rtl/tlsd_loop.sv
module tlsd_loop
  import tlsd_pkg::*;
#(
  parameter int DW = 16,
  parameter int VW = DW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  output trit_e                q_nxt,
  output logic signed [VW-1:0] e1_o,
  output logic signed [VW-1:0] e2_o
);

  localparam int FS  = 1 << (DW - 1);
  localparam int THR = FS / 2;
  localparam int LIM = 2 * FS - 1;
  localparam logic signed [VW-1:0] FS_V  = VW'(FS);
  localparam logic signed [VW-1:0] THR_V = VW'(THR);
  localparam logic signed [VW-1:0] LIM_V = VW'(LIM);

  // Ternary slicer with symmetric thresholds at half of full scale.
  function automatic trit_e quantize(logic signed [VW-1:0] v);
    if (v > THR_V)       return TRIT_POS;
    else if (v < -THR_V) return TRIT_NEG;
    else                 return TRIT_ZERO;
  endfunction

  // Loop value minus the fed-back decision.
  function automatic logic signed [VW-1:0] residual(logic signed [VW-1:0] v, trit_e t);
    case (t)
      TRIT_POS: return v - FS_V;
      TRIT_NEG: return v + FS_V;
      default:  return v;
    endcase
  endfunction

  // Clamp of stored error to the fixed bound.
  function automatic logic signed [VW-1:0] clamp(logic signed [VW-1:0] r);
    if (r > LIM_V)       return LIM_V;
    else if (r < -LIM_V) return -LIM_V;
    else                 return r;
  endfunction

  logic signed [VW-1:0] e_hist [2];
  logic signed [VW-1:0] x_ext;
  logic signed [VW-1:0] v_loop;
  logic signed [VW-1:0] e_new;

  assign x_ext  = {{(VW-DW){x[DW-1]}}, x};
  // Second-order error feedback: NTF = (1 - z^-1)^2.
  assign v_loop = x_ext + (e_hist[0] <<< 1) - e_hist[1];
  assign q_nxt  = quantize(v_loop);
  assign e_new  = clamp(residual(v_loop, q_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_hist[0] <= '0;
      e_hist[1] <= '0;
    end else if (!en) begin
      e_hist[0] <= '0;
      e_hist[1] <= '0;
    end else begin
      e_hist[1] <= e_hist[0];
      e_hist[0] <= e_new;
    end
  end

  assign e1_o = e_hist[0];
  assign e2_o = e_hist[1];

endmodule

// File: rtl/tlsd_legmap.sv
module tlsd_legmap
  import tlsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  trit_e      q,
  output logic       leg_p,
  output logic       leg_n,
  output logic [1:0] level
);

  logic [1:0] drv;
  assign drv = drive_of(q);

  // All outputs come straight from flops, so the switch drives are glitch-free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_p <= 1'b0;
      leg_n <= 1'b0;
      level <= TRIT_ZERO;
    end else if (!en) begin
      leg_p <= 1'b0;
      leg_n <= 1'b0;
      level <= TRIT_ZERO;
    end else begin
      leg_p <= drv[1];
      leg_n <= drv[0];
      level <= q;
    end
  end

endmodule

// File: rtl/tlsd_mod.sv
module tlsd_mod
  import tlsd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  output logic                 leg_p,
  output logic                 leg_n,
  output logic [1:0]           level
);

  localparam int VW  = DW + 3;
  localparam int LIM = 2 * (1 << (DW - 1)) - 1;

  logic signed [DW-1:0] x_held;
  trit_e                q_nxt;
  logic signed [VW-1:0] err1;
  logic signed [VW-1:0] err2;

  tlsd_hold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .held      (x_held)
  );

  tlsd_loop #(.DW(DW), .VW(VW)) u_loop (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .x     (x_held),
    .q_nxt (q_nxt),
    .e1_o  (err1),
    .e2_o  (err2)
  );

  tlsd_legmap u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .q     (q_nxt),
    .leg_p (leg_p),
    .leg_n (leg_n),
    .level (level)
  );

endmodule

// File: rtl/tlsd_mod_chk.sv
module tlsd_mod_chk #(
  parameter int DW  = 16,
  parameter int VW  = DW + 3,
  parameter int LIM = 65535
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 leg_p,
  input logic                 leg_n,
  input logic [1:0]           level,
  input logic signed [DW-1:0] x_held,
  input logic signed [VW-1:0] err1,
  input logic signed [VW-1:0] err2
);

  localparam logic signed [VW-1:0] LIM_V = VW'(LIM);

  // R1
  level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b10);

  // R2
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_p && leg_n));

  // R2
  legs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_p == (level == 2'b01)) && (leg_n == (level == 2'b11)));

  // R7
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!leg_p && !leg_n && level == 2'b00 && err1 == '0 && err2 == '0));

  // R8
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err1 <= LIM_V) && (err1 >= -LIM_V) && (err2 <= LIM_V) && (err2 >= -LIM_V));

  // R4
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && x_held == '0 && err1 == '0 && err2 == '0) |=> (level == 2'b00));

endmodule

bind tlsd_mod tlsd_mod_chk #(.DW(DW), .VW(VW), .LIM(LIM)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .leg_p  (leg_p),
  .leg_n  (leg_n),
  .level  (level),
  .x_held (x_held),
  .err1   (err1),
  .err2   (err2)
);

// File: tb/sim_tlsd_mod.sv
`timescale 1ns/1ps
module sim_tlsd_mod;

  localparam int DW  = 16;
  localparam int FS  = 1 << (DW - 1);
  localparam int LIM = 2 * FS - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 en = 1'b0;
  logic                 smp_valid = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic                 leg_p, leg_n;
  logic [1:0]           level;

  always #10 clk = ~clk; // 50 MHz

  tlsd_mod #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid),
    .smp_data(smp_data), .leg_p(leg_p), .leg_n(leg_n), .level(level)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  int acc_sum = 0;
  int acc_nz = 0;
  bit finished = 0;

  // Reference model state: integer restatement of the loop equations.
  int m_x = 0, m_e1 = 0, m_e2 = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver-side model: pushes the expected decision for every edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_x = 0; m_e1 = 0; m_e2 = 0;
    end else begin
      int v, q, r;
      q = 0;
      if (en) begin
        v = m_x + 2 * m_e1 - m_e2;
        q = (v > FS / 2) ? 1 : ((v < -(FS / 2)) ? -1 : 0);
        r = v - q * FS;
        if (r > LIM) r = LIM;
        if (r < -LIM) r = -LIM;
        m_e2 = m_e1;
        m_e1 = r;
      end else begin
        m_e1 = 0; m_e2 = 0;
      end
      exp_q.push_back(q);
      if (smp_valid) m_x = int'(smp_data);
    end
  end

  // Monitor: pops one expected decision per cycle and compares.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e, act;
      logic [1:0] ecode;
      e = exp_q.pop_front();
      ecode = (e == 1) ? 2'b01 : ((e == -1) ? 2'b11 : 2'b00);
      act = (level == 2'b01) ? 1 : ((level == 2'b11) ? -1 : ((level == 2'b00) ? 0 : 9));
      check(level != 2'b10, "R1", "illegal level code", int'(level), int'(ecode));
      check(level == ecode, "R3", "level", int'(level), int'(ecode));
      check(leg_p == ecode[0] && !ecode[1] || leg_p == 1'b0 && ecode != 2'b01,
            "R2", "leg_p", int'(leg_p), int'(ecode == 2'b01));
      check(leg_n == (ecode == 2'b11), "R2", "leg_n", int'(leg_n), int'(ecode == 2'b11));
      if (act != 9) begin
        acc_sum += act;
        if (act != 0) acc_nz++;
      end
    end
  end

  // Clear the loop with enable low, load a sample, then run n cycles.
  task automatic run_const(int x, int n);
    @(negedge clk);
    en = 1'b0; smp_valid = 1'b1; smp_data = DW'(x);
    @(negedge clk);
    smp_valid = 1'b0; en = 1'b1;
    #1 acc_sum = 0; acc_nz = 0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int s64, s128, s256, sneg;
    repeat (3) @(negedge clk);
    // R7: outputs parked during reset
    check(!leg_p && !leg_n, "R7", "legs in reset", int'({leg_p, leg_n}), 0);
    check(level == 2'b00, "R7", "level in reset", int'(level), 0);
    rst_n = 1'b1;

    // R4: zero input gives no pulses
    run_const(0, 200);
    check(acc_nz == 0, "R4", "pulses at zero input", acc_nz, 0);

    // R5: density follows magnitude and sign
    run_const(FS / 16, 1024); s64 = acc_sum;
    check(s64 >= 56 && s64 <= 72, "R5", "net sum FS/16", s64, 64);
    run_const(FS / 8, 1024); s128 = acc_sum;
    check(s128 >= 120 && s128 <= 136, "R5", "net sum FS/8", s128, 128);
    run_const(FS / 4, 1024); s256 = acc_sum;
    check(s256 >= 248 && s256 <= 264, "R5", "net sum FS/4", s256, 256);
    run_const(-(FS / 4), 1024); sneg = acc_sum;
    check(sneg >= -264 && sneg <= -248, "R5", "net sum -FS/4", sneg, -256);
    check(s64 < s128 && s128 < s256, "R5", "density order", s256 - s128, 1);

    // R6: unstrobed sample changes are ignored
    run_const(0, 4);
    acc_nz = 0;
    for (int i = 0; i < 64; i++) begin
      smp_data = DW'(20000 - i * 300);
      @(negedge clk);
    end
    #1 check(acc_nz == 0, "R6", "pulses without strobe", acc_nz, 0);
    smp_valid = 1'b1; smp_data = DW'(12000);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (40) @(negedge clk);
    #1 check(acc_nz > 0, "R6", "strobed sample takes effect", acc_nz, 1);

    // R7: disable mid-run parks and clears, restart is clean
    @(negedge clk); en = 1'b0; smp_valid = 1'b1; smp_data = '0;
    @(negedge clk); smp_valid = 1'b0;
    #1 check(level == 2'b00 && !leg_p && !leg_n, "R7", "parked after en low", int'(level), 0);
    en = 1'b1; acc_nz = 0;
    repeat (100) @(negedge clk);
    #1 check(acc_nz == 0, "R7", "clean restart", acc_nz, 0);

    // R8: full-scale overload in both directions (exact model compare)
    run_const(-FS, 300);
    check(acc_sum < 0, "R8", "negative overload sign", acc_sum, -1);
    run_const(FS - 1, 300);
    check(acc_sum > 0, "R8", "positive overload sign", acc_sum, 1);

    // R3: moving input with sparse strobes
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      smp_valid = (i % 4 == 0);
      smp_data = DW'(((i % 64) - 32) * 400);
    end
    @(negedge clk); smp_valid = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule